// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a phase-locked loop. A free-running divider clock enters a fixed pre-divider (divide-by-4 by default). Its output feeds a dual-modulus prescaler that divides by either P or P+1. Two down-counters steer the prescaler. The swallow count A sets how many prescaler periods use P+1. The main count B sets how many prescaler periods make up one full division cycle. At the end of every division cycle the block emits a one-clock pulse for the phase detector.

The prescaler pair is chosen at run time from four options by a 2-bit code. The ratio seen at the output is therefore FIXED_DIV·(B·P + A) divider-clock cycles.

The A, B and P settings are sampled only at a division-cycle boundary. Software can therefore rewrite them at any time without producing a short or long cycle. A synchronous counter-reset input holds every counter in its load state, so that the divider can be restarted in a known phase.

Top module: `swallow_fbdiv`

## Requirements
- R1: The 2-bit prescaler code selects the modulus pair: 00 selects 8/9, 01 selects 16/17, 10 selects 32/33 and 11 selects 64/65.
- R2: With legal settings (2 ≤ B, A ≤ B), consecutive output pulses are exactly 4·(B·P + A) divider-clock cycles apart, where P is the lower modulus of the selected pair.
- R3: Within each division cycle the first A prescaler periods use P+1 and the remaining B−A use P. A = 0 therefore gives 4·B·P, and A = B gives 4·B·(P+1).
- R4: Each output pulse is high for exactly one divider-clock cycle.
- R5: While the counter-reset input is 1, no pulse is produced and all counters stay in their load state, tracking the current A, B and P inputs. The first pulse comes 4·(B·P + A) clocks after the first rising edge at which the input is back at 0.
- R6: A, B and P are captured only when a division cycle ends. If they change mid-cycle, the cycle in progress keeps its old ratio and the next cycle uses the new one.
- R7: A synchronous active-low reset clears the output and loads the counters from the inputs. The first pulse comes 4·(B·P + A) clocks after the first rising edge with reset released.
- R8: A spans the full 6-bit range 0 to 63 and B is a 13-bit value, so settings such as A = 63 with B = 63, or B = 300, divide correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_rst | input | 1 | Counter reset: holds all counters in load state while 1 |
| psel | input | 2 | Prescaler pair code (00: 8/9, 01: 16/17, 10: 32/33, 11: 64/65) |
| a_val | input | 6 | Swallow count A, 0 to 63, not above B |
| b_val | input | 13 | Main count B, 2 to 8191 |
| div_out | output | 1 | One-clock pulse at the end of each division cycle |

## Verification
Each prescaler code is tried with the same small A and B. Because the pairs differ, a wrong code decode shows up directly as a different pulse spacing. The two swallow extremes, A = 0 and A = B, separate a modulus-control fault from a plain counting fault. Every setting change is made mid-cycle, so one interval must keep the old ratio before the next takes the new one, which exposes any early capture of the settings. Random legal triples, a restart from counter reset with new values loaded during the hold, and large A and B values complete the set.

// File: rtl/swdiv_pkg.sv
// Shared definitions for the pulse-swallow feedback divider.
// Assumes the prescaler pairs are fixed at 8/9, 16/17, 32/33 and 64/65.
package swdiv_pkg;

    localparam int PSEL_W = 2;
    localparam int MOD_W  = 7;   // wide enough for the largest modulus, 65

    typedef enum logic [PSEL_W-1:0] {
        PS_8_9   = 2'b00,
        PS_16_17 = 2'b01,
        PS_32_33 = 2'b10,
        PS_64_65 = 2'b11
    } psel_e;

    // Lower modulus P of the selected pair: 8 shifted left by the code
    function automatic logic [MOD_W-1:0] base_modulus(input psel_e code);
        return MOD_W'(8) << code;
    endfunction

endpackage

// File: rtl/swdiv_fixed_stage.sv
// Fixed pre-divider ahead of the dual-modulus prescaler.
// Emits one tick every FIXED_DIV clocks. Assumes FIXED_DIV >= 2.
// While hold is 1 the counter sits at zero and no tick is issued.
module swdiv_fixed_stage #(
    parameter int FIXED_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int FC_W = (FIXED_DIV > 2) ? $clog2(FIXED_DIV) : 1;
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(FIXED_DIV - 1);

    logic [FC_W-1:0] fc;

    // Tick on the last count of the fixed ratio, never during hold
    assign tick = (fc == FC_LAST) && !hold;

    // Free-running phase counter of the fixed stage
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            fc <= '0;
        end else if (tick) begin
            fc <= '0;
        end else begin
            fc <= fc + FC_W'(1);
        end
    end

    // R2: ticks are never back to back, since the fixed ratio is at least 2
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/swdiv_prescaler.sv
// Dual-modulus prescaler: counts input ticks and divides by P or by P+1,
// as chosen by swallow. Assumes psel and swallow change only when a
// period ends, which the swallow controller guarantees.
module swdiv_prescaler
    import swdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  tick,
    input  psel_e psel,
    input  logic  swallow,
    output logic  period_end
);
    logic [MOD_W-1:0] pc;
    logic [MOD_W-1:0] modulus;

    // Modulus of the current period: P, or P+1 while swallowing
    assign modulus    = base_modulus(psel) + MOD_W'(swallow);
    assign period_end = tick && (pc == modulus - MOD_W'(1));

    // Count ticks within one prescaler period
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pc <= '0;
        end else if (tick) begin
            pc <= period_end ? '0 : pc + MOD_W'(1);
        end
    end

    // R1: the period count never reaches the selected modulus
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pc < modulus);

endmodule

// File: rtl/swdiv_swallow_ctrl.sv
// Swallow and main counters. a_rem counts the remaining P+1 periods and
// b_rem the remaining periods of the division cycle. The settings are
// captured at cycle end, during hold and in reset. Assumes A <= B and B >= 2.
module swdiv_swallow_ctrl
    import swdiv_pkg::*;
#(
    parameter int A_W = 6,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           period_end,
    input  logic [A_W-1:0] cfg_a,
    input  logic [B_W-1:0] cfg_b,
    input  psel_e          cfg_p,
    output logic           swallow,
    output psel_e          p_lat,
    output logic           cycle_end
);
    logic [A_W-1:0] a_rem;
    logic [B_W-1:0] b_rem;

    // Use P+1 while swallow periods remain; the cycle ends on its last period
    assign swallow   = (a_rem != '0);
    assign cycle_end = period_end && (b_rem == B_W'(1));

    // Reload at a boundary, otherwise count down once per prescaler period
    always_ff @(posedge clk) begin
        if (!rst_n || hold || cycle_end) begin
            a_rem <= cfg_a;
            b_rem <= cfg_b;
            p_lat <= cfg_p;
        end else if (period_end) begin
            b_rem <= b_rem - B_W'(1);
            if (swallow) begin
                a_rem <= a_rem - A_W'(1);
            end
        end
    end

    // R3: the swallow periods always fit inside the main count
    a_r3_swallow_within_main: assert property (@(posedge clk) disable iff (!rst_n)
        B_W'(a_rem) <= b_rem);

endmodule

// File: rtl/swallow_fbdiv.sv
// Top of the pulse-swallow feedback divider: fixed pre-divider, then the
// dual-modulus prescaler, then the swallow/main counters. Issues a one-clock
// pulse every FIXED_DIV*(B*P+A) clocks. Assumes 2 <= B and A <= B.
module swallow_fbdiv
    import swdiv_pkg::*;
#(
    parameter int A_W       = 6,
    parameter int B_W       = 13,
    parameter int FIXED_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_rst,
    input  logic [PSEL_W-1:0] psel,
    input  logic [A_W-1:0]    a_val,
    input  logic [B_W-1:0]    b_val,
    output logic              div_out
);
    logic  fixed_tick;
    logic  period_end;
    logic  swallow;
    logic  cycle_end;
    psel_e p_lat;
    psel_e cfg_p;

    assign cfg_p = psel_e'(psel);

    swdiv_fixed_stage #(
        .FIXED_DIV (FIXED_DIV)
    ) u_fixed (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (cnt_rst),
        .tick  (fixed_tick)
    );

    swdiv_prescaler u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (cnt_rst),
        .tick       (fixed_tick),
        .psel       (p_lat),
        .swallow    (swallow),
        .period_end (period_end)
    );

    swdiv_swallow_ctrl #(
        .A_W (A_W),
        .B_W (B_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (cnt_rst),
        .period_end (period_end),
        .cfg_a      (a_val),
        .cfg_b      (b_val),
        .cfg_p      (cfg_p),
        .swallow    (swallow),
        .p_lat      (p_lat),
        .cycle_end  (cycle_end)
    );

    // Register the end-of-cycle marker as the output pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_out <= 1'b0;
        end else begin
            div_out <= cycle_end;
        end
    end

    // R4: the output pulse lasts one clock
    a_r4_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R5: no pulse follows a clock spent in counter reset
    a_r5_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> !div_out);

endmodule

// File: tb/tb_swallow_fbdiv.sv
module tb_swallow_fbdiv;

    logic        clk     = 1'b0;
    logic        rst_n   = 1'b0;
    logic        cnt_rst = 1'b0;
    logic [1:0]  psel    = 2'b00;
    logic [5:0]  a_val   = 6'd0;
    logic [12:0] b_val   = 13'd2;
    logic        div_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    swallow_fbdiv dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_rst (cnt_rst),
        .psel    (psel),
        .a_val   (a_val),
        .b_val   (b_val),
        .div_out (div_out)
    );

    function automatic int exp_n(input int p, input int a, input int b);
        return 4 * (b * (8 << p) + a);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic set_cfg(input int p, input int a, input int b);
        psel  = 2'(p);
        a_val = 6'(a);
        b_val = 13'(b);
    endtask

    // Count negedges until the next pulse; the first one must be low (R4)
    task automatic next_interval(output int n);
        n = 0;
        @(negedge clk);
        n = 1;
        check(div_out == 1'b0, "R4 pulse one clock wide", int'(div_out), 0);
        while (!div_out && n < 30000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic expect_interval(input string tag, input int expv);
        int n;
        next_interval(n);
        check(n == expv, tag, n, expv);
    endtask

    // Change settings mid-cycle: old ratio once (R6), then the new one
    task automatic change_and_check(input string tag, input int p, input int a,
                                    input int b, inout int cur);
        set_cfg(p, a, b);
        expect_interval({tag, " / R6 cycle in progress keeps old ratio"}, cur);
        cur = exp_n(p, a, b);
        expect_interval(tag, cur);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        int cur;
        int p;
        int a;
        int b;
        void'($urandom(32'd24681));
        set_cfg(0, 1, 2);
        cur = exp_n(0, 1, 2);
        repeat (5) @(negedge clk);
        check(div_out == 1'b0, "R7 output low in reset", int'(div_out), 0);
        rst_n = 1'b1;
        expect_interval("R7 first pulse after reset release", cur);
        expect_interval("R2 steady period", cur);

        change_and_check("R1 code 01 gives 16/17", 1, 1, 2, cur);
        change_and_check("R1 code 10 gives 32/33", 2, 1, 2, cur);
        change_and_check("R1 code 11 gives 64/65", 3, 1, 2, cur);
        change_and_check("R1 code 00 gives 8/9", 0, 3, 5, cur);

        change_and_check("R3 no swallow A=0", 0, 0, 5, cur);
        change_and_check("R3 all swallow A=B", 1, 7, 7, cur);

        change_and_check("R8 A at 63", 0, 63, 63, cur);
        change_and_check("R8 large B", 0, 40, 300, cur);

        // R5: enter counter reset mid-cycle, load new settings during hold
        repeat (37) @(negedge clk);
        cnt_rst = 1'b1;
        set_cfg(2, 3, 4);
        cur = exp_n(2, 3, 4);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check(div_out == 1'b0, "R5 no pulse in counter reset", int'(div_out), 0);
        end
        cnt_rst = 1'b0;
        expect_interval("R5 first pulse after counter reset release", cur);
        expect_interval("R5 steady period after restart", cur);

        for (int i = 0; i < 12; i++) begin
            p = int'($urandom % 4);
            b = 2 + int'($urandom % 11);
            a = int'($urandom % (b + 1));
            change_and_check("R2 random legal setting", p, a, b, cur);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles at most", 195000, 195000);
            summary();
            $finish;
        end
    end

endmodule